// File: doc/BRIEF.md
# Bit-Interleaved Four-Channel T1 Stream Splitter

This block takes one high-speed serial stream in which four DS1 tributaries are bit-interleaved with filler. It breaks that stream back into four separate per-channel bit streams. Every clock of the high-speed clock carries one slot. A group of eight slots carries one bit of each tributary. The even slots 0, 2, 4 and 6 belong to channels 0, 1, 2 and 3. The odd slots hold filler and are thrown away. Eight slots per channel bit at 12.352 Mbit/s gives each tributary its 1.544 Mbit/s rate.

A one-clock sync pulse marks the slot that holds the framing bit of channel 0. The block locks its slot and bit counters to that pulse. After that it free-runs over the 193-bit DS1 frame. Whenever a new pulse arrives it realigns to it. A pulse that lands anywhere other than the expected frame start sets a sticky misalignment flag.

Each channel output is a valid strobe with its data bit and a frame-start flag. The output has no ready signal. The input stream runs at a fixed line rate and cannot be stalled, so back-pressure is not possible. A consumer must take each bit in the cycle its strobe is high.

Top module: `t1_bitmux_demux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is 0: all strobes, all frame flags, all data bits and the misalignment flag.
- R2: Until the first sync pulse after reset, no channel strobe rises, whatever data is on the serial input.
- R3: The slot sampled together with a sync pulse is slot 0. Channel k takes the bit in slot 2k of each eight-slot group, and the bits in odd slots never reach any output.
- R4: Channel k raises its strobe for exactly one cycle, one cycle after its slot is sampled. It presents that slot's bit on its data output in the same cycle, so each channel strobes once every 8 clocks.
- R5: A frame flag is high only together with its channel's strobe, and only for the bit at frame position 0: the group that starts at a sync pulse, and every 193rd group after it.
- R6: Once locked, the block tracks frames without further pulses. A pulse that arrives exactly at the expected frame start (slot 0, bit 0) leaves the misalignment flag clear.
- R7: A sync pulse at any other slot or bit position, once locked, sets the misalignment flag. That pulse becomes the new slot 0, bit 0.
- R8: The misalignment flag stays set until reset, including across later correctly placed pulses.
- R9: At most one channel strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed slot clock, one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Bit-interleaved serial stream |
| ser_sync | input | 1 | One-cycle pulse on channel 0 framing-bit slot |
| ch_data | output | NUM_CH | Per-channel data bit, valid with its strobe |
| ch_strobe | output | NUM_CH | Per-channel one-cycle bit-valid strobe |
| ch_frame | output | NUM_CH | Per-channel frame-start flag, valid with its strobe |
| misalign | output | 1 | Sticky flag: sync seen away from expected frame start |

## Verification
The assertions check the following on every cycle:
- Strobes stay silent before the first sync.
- Strobes are mutually exclusive and a single cycle wide.
- A frame flag is never high without its strobe.
- A sync pulse always produces a channel 0 strobe with its frame flag in the next cycle.
- The misalignment flag never falls.

Only the bench scenarios can show the remaining behaviour:
- Filler slots are discarded and each channel receives the correct bit value.
- The 193-bit frame count keeps running without pulses.
- A correctly placed pulse leaves the flag clear, while a misplaced one sets it and shifts the alignment.

// File: rtl/t1_demux_pkg.sv
package t1_demux_pkg;

  typedef enum logic {
    TRK_HUNT   = 1'b0,
    TRK_LOCKED = 1'b1
  } trk_state_e;

  // Slot carrying channel ch when channels occupy every STRIDE-th slot.
  function automatic int unsigned lane_slot(input int unsigned ch,
                                            input int unsigned stride);
    return ch * stride;
  endfunction

endpackage

// File: rtl/t1_slot_tracker.sv
module t1_slot_tracker
  import t1_demux_pkg::*;
#(
  parameter int unsigned SLOTS_PER_BIT = 8,
  parameter int unsigned FRAME_BITS    = 193,
  localparam int unsigned SLOT_W = $clog2(SLOTS_PER_BIT),
  localparam int unsigned BIT_W  = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              cur_frame_bit,
  output logic              active,
  output logic              misalign
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_BIT - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(FRAME_BITS - 1);

  trk_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BIT_W-1:0]  cur_bit;
  logic [SLOT_W-1:0] slot_nxt;
  logic [BIT_W-1:0]  bit_nxt;
  logic              off_target;
  logic              mis_q;

  // A sync pulse forces the current slot to position zero of the frame.
  always_comb begin
    cur_slot      = sync_in ? '0 : slot_q;
    cur_bit       = sync_in ? '0 : bit_q;
    cur_frame_bit = (cur_bit == '0);
    active        = (state_q == TRK_LOCKED) || sync_in;
    off_target    = sync_in && (state_q == TRK_LOCKED) &&
                    ((slot_q != '0) || (bit_q != '0));
  end

  always_comb begin
    slot_nxt = (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
    bit_nxt  = cur_bit;
    if (cur_slot == LAST_SLOT) begin
      bit_nxt = (cur_bit == LAST_BIT) ? '0 : cur_bit + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_HUNT;
      slot_q  <= '0;
      bit_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      slot_q <= slot_nxt;
      bit_q  <= bit_nxt;
      if (sync_in) begin
        state_q <= TRK_LOCKED;
      end
      if (off_target) begin
        mis_q <= 1'b1;
      end
    end
  end

  assign misalign = mis_q;

endmodule

// File: rtl/t1_channel_lane.sv
module t1_channel_lane #(
  parameter int unsigned SLOT_W   = 3,
  parameter int unsigned MY_SLOT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [SLOT_W-1:0] cur_slot,
  input  logic              frame_bit,
  input  logic              ser_data,
  output logic              lane_data,
  output logic              lane_strobe,
  output logic              lane_frame
);

  localparam logic [SLOT_W-1:0] SLOT_ID = SLOT_W'(MY_SLOT);

  logic take;

  assign take = active && (cur_slot == SLOT_ID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_data   <= 1'b0;
      lane_strobe <= 1'b0;
      lane_frame  <= 1'b0;
    end else begin
      lane_strobe <= take;
      lane_frame  <= take && frame_bit;
      if (take) begin
        lane_data <= ser_data;
      end
    end
  end

endmodule

// File: rtl/t1_bitmux_demux.sv
module t1_bitmux_demux
  import t1_demux_pkg::*;
#(
  parameter int unsigned NUM_CH        = 4,
  parameter int unsigned SLOTS_PER_BIT = 8,
  parameter int unsigned FRAME_BITS    = 193
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_sync,
  output logic [NUM_CH-1:0] ch_data,
  output logic [NUM_CH-1:0] ch_strobe,
  output logic [NUM_CH-1:0] ch_frame,
  output logic              misalign
);

  localparam int unsigned SLOT_W = $clog2(SLOTS_PER_BIT);
  localparam int unsigned STRIDE = SLOTS_PER_BIT / NUM_CH;

  logic [SLOT_W-1:0] cur_slot;
  logic              cur_frame_bit;
  logic              active;

  t1_slot_tracker #(
    .SLOTS_PER_BIT (SLOTS_PER_BIT),
    .FRAME_BITS    (FRAME_BITS)
  ) u_tracker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_in       (ser_sync),
    .cur_slot      (cur_slot),
    .cur_frame_bit (cur_frame_bit),
    .active        (active),
    .misalign      (misalign)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    t1_channel_lane #(
      .SLOT_W  (SLOT_W),
      .MY_SLOT (lane_slot(g, STRIDE))
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (active),
      .cur_slot    (cur_slot),
      .frame_bit   (cur_frame_bit),
      .ser_data    (ser_data),
      .lane_data   (ch_data[g]),
      .lane_strobe (ch_strobe[g]),
      .lane_frame  (ch_frame[g])
    );
  end

endmodule

// File: rtl/t1_bitmux_demux_chk.sv
module t1_bitmux_demux_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_sync,
  input logic [NUM_CH-1:0] ch_strobe,
  input logic [NUM_CH-1:0] ch_frame,
  input logic              misalign
);

  logic seen_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_sync_q <= 1'b0;
    else if (ser_sync) seen_sync_q <= 1'b1;
  end

  assert_quiet_before_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_sync_q |-> (ch_strobe == '0));

  assert_sync_to_ch0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sync |=> (ch_strobe[0] && ch_frame[0]));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ch_strobe[0] |=> !ch_strobe[0]);

  assert_frame_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_frame & ~ch_strobe) == '0);

  assert_misalign_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> misalign);

  assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_strobe));

endmodule

bind t1_bitmux_demux t1_bitmux_demux_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_sync  (ser_sync),
  .ch_strobe (ch_strobe),
  .ch_frame  (ch_frame),
  .misalign  (misalign)
);

// File: tb/test_t1_bitmux_demux.sv
module test_t1_bitmux_demux;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 4;
  localparam int SLOTS = 8;
  localparam int FBITS = 193;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ser_data = 1'b0;
  logic           ser_sync = 1'b0;
  logic [NCH-1:0] ch_data, ch_strobe, ch_frame;
  logic           misalign;

  int checks = 0;
  int failures = 0;

  // reference model state
  int   m_slot = 0, m_bit = 0;
  bit   m_locked = 0, m_mis = 0;
  logic [NCH-1:0] e_data = '0, e_strobe = '0, e_frame = '0;
  logic           e_mis = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  t1_bitmux_demux #(.NUM_CH(NCH), .SLOTS_PER_BIT(SLOTS), .FRAME_BITS(FBITS))
    i_t1_bitmux_demux (
      .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_sync(ser_sync),
      .ch_data(ch_data), .ch_strobe(ch_strobe), .ch_frame(ch_frame),
      .misalign(misalign));

  function automatic logic pat_bit(input int ch, input int b);
    return logic'((((b * 37) + (ch * 11) + ((b >> 3) * ch)) % 7) < 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Compare outputs of the last edge, then drive the next slot and predict.
  task automatic step(input logic sd, input logic sy);
    int  cs, cb;
    bit  act;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      check(ch_strobe[ch] === e_strobe[ch], m_locked ? "R4" : "R2",
            $sformatf("strobe ch%0d", ch), ch_strobe[ch], e_strobe[ch]);
      check(ch_frame[ch] === e_frame[ch], "R5",
            $sformatf("frame ch%0d", ch), ch_frame[ch], e_frame[ch]);
      if (e_strobe[ch])
        check(ch_data[ch] === e_data[ch], "R3",
              $sformatf("data ch%0d", ch), ch_data[ch], e_data[ch]);
    end
    check($countones(ch_strobe) <= 1, "R9", "strobe overlap",
          $countones(ch_strobe), 1);
    check(misalign === e_mis, "R7", "misalign", misalign, e_mis);
    cs = sy ? 0 : m_slot;
    cb = sy ? 0 : m_bit;
    if (sy && m_locked && (m_slot != 0 || m_bit != 0)) m_mis = 1;
    act = m_locked || sy;
    e_strobe = '0;
    e_frame  = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      if (act && cs == 2 * ch) begin
        e_strobe[ch] = 1'b1;
        e_data[ch]   = sd;
        e_frame[ch]  = (cb == 0);
      end
    end
    e_mis = m_mis;
    if (sy) m_locked = 1;
    m_slot = (cs + 1) % SLOTS;
    m_bit  = (cs == SLOTS - 1) ? (cb + 1) % FBITS : cb;
    ser_data = sd;
    ser_sync = sy;
  endtask

  task automatic send_frame(input bit with_sync, input int nbits);
    for (int b = 0; b < nbits; b++)
      for (int s = 0; s < SLOTS; s++)
        step((s % 2 == 0) ? pat_bit(s / 2, b) : logic'($urandom % 2),
             logic'(with_sync && b == 0 && s == 0));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ser_sync = 1'b0; ser_data = 1'b0;
    m_slot = 0; m_bit = 0; m_locked = 0; m_mis = 0;
    e_data = '0; e_strobe = '0; e_frame = '0; e_mis = 1'b0;
    repeat (3) @(negedge clk);
    check(ch_strobe === '0 && ch_frame === '0 && ch_data === '0 && misalign === 1'b0,
          "R1", "outputs in reset", int'({ch_strobe, ch_frame, ch_data, misalign}), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R2: random data, no sync, no strobes
    for (int i = 0; i < 120; i++) step(logic'($urandom % 2), 1'b0);
    // R3 R4 R5: locked frames, second sync exactly on expected start (R6)
    send_frame(1'b1, FBITS);
    send_frame(1'b1, FBITS);
    send_frame(1'b0, FBITS);
    send_frame(1'b1, FBITS);
    step(1'b0, 1'b0);
    check(misalign === 1'b0, "R6", "aligned sync kept flag clear", misalign, 0);
    // R7: partial frame then extra slots, then early sync
    send_frame(1'b0, 59);
    for (int i = 0; i < 3; i++) step(logic'($urandom % 2), 1'b0);
    send_frame(1'b1, FBITS);
    check(misalign === 1'b1, "R7", "misplaced sync flagged", misalign, 1);
    // R8: flag survives a correct sync
    send_frame(1'b1, FBITS);
    step(1'b0, 1'b0);
    check(misalign === 1'b1, "R8", "flag sticky", misalign, 1);
    // R1: reset clears it; R2 again then relock
    do_reset();
    step(1'b0, 1'b0);
    check(misalign === 1'b0, "R1", "flag cleared by reset", misalign, 0);
    for (int i = 0; i < 20; i++) step(logic'($urandom % 2), 1'b0);
    send_frame(1'b1, FBITS);
    step(1'b0, 1'b0);
    summary();
    $finish;
  end

endmodule